// File: doc/BRIEF.md
# Shutter, T0-Sync and Busy Controller

This block sits between one detector readout board and a shared timing unit. When a sync request arrives, it runs a fixed sequence. First it closes the pixel shutter. Then it drives the T0-sync pulse, and can drive a chip reset alongside it. Last, it reopens the shutter after a guaranteed closed window. Every chip that receives the same T0-sync then counts time from a common origin. While the shutter is closed the chips produce no hit data, so the sync never cuts through a hit.

The same block also drives the board's outgoing busy line. Busy is raised whenever the transmit buffer reports it is nearly full. A host halt command latches busy high until the host clears it. A combiner then ORs this local busy with the busy lines of the other boards, which gives the single busy line that the timing unit sees.

All the pins are plain control and status signals. There is no data stream and no handshake. The pulse width and the closed-window length come from two configuration registers. A write can never set either register below its safe minimum. All timing is counted in cycles of the timing clock. At 40 MHz, one cycle is 25 ns and 64 cycles are 1.6 µs.

Top module: `sync_shutter_ctrl`

## Requirements
- R1: After reset, `t0_sync_o`, `chip_rst_o` and `sync_done_o` are low, and `shutter_o` follows `shutter_en`. The pulse register holds MIN_PULSE (1) and the window register holds MIN_WIN (65).
- R2: A `sync_req` that is sampled while no sequence runs closes the shutter in the next cycle. `t0_sync_o` rises exactly one cycle after the shutter closes, and it is never high while `shutter_o` is high.
- R3: `t0_sync_o` stays high for exactly P consecutive cycles, where P is the pulse register value.
- R4: The shutter stays closed for exactly max(W, P+2) cycles, where W is the window register value. With the defaults this is 65 cycles, which is more than 64 cycles (1.6 µs).
- R5: If `chip_rst_en` is high when the sequence starts, `chip_rst_o` is high in exactly the cycles where `t0_sync_o` is high. Otherwise `chip_rst_o` stays low for the whole sequence.
- R6: `sync_done_o` is high for one cycle: the first cycle in which the shutter is open again.
- R7: A `sync_req` that arrives while a sequence is running is ignored. It does not lengthen the sequence and it does not start a new one.
- R8: A `cfg_wr` with `cfg_addr`=0 writes the pulse register. A `cfg_wr` with `cfg_addr`=1 writes the window register. A value below the register's minimum is stored as that minimum. P, W and `chip_rst_en` are captured when a sequence starts, so writes made during a sequence only affect the next one.
- R9: `busy_o` is high in any cycle where `buf_afull` is high or the halt flag is set. A `halt_set` pulse sets the flag and a `halt_clr` pulse clears it; if both arrive in the same cycle, the set wins. The flag takes effect in the cycle after the pulse.
- R10: `busy_all_o` is the OR of `busy_o` and every bit of `remote_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shutter_en | input | 1 | Host wants the shutter open |
| sync_req | input | 1 | Starts a sync sequence |
| chip_rst_en | input | 1 | Add a chip reset pulse to the next sequence |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = pulse length register, 1 = window length register |
| cfg_wdata | input | 16 | Write value in cycles |
| buf_afull | input | 1 | Transmit buffer almost-full flag |
| halt_set | input | 1 | Host halt command |
| halt_clr | input | 1 | Host halt release |
| remote_busy | input | 3 | Busy lines from the other boards |
| shutter_o | output | 1 | Shutter to the chips (high = open) |
| t0_sync_o | output | 1 | T0-sync pulse |
| chip_rst_o | output | 1 | Optional chip reset pulse |
| sync_done_o | output | 1 | One-cycle pulse when the shutter reopens |
| busy_o | output | 1 | This board's busy |
| busy_all_o | output | 1 | Combined busy of all boards |

## Verification
The assertions make a few assumptions about the inputs. They assume reset is applied before the first sequence. They assume the window register is never below its minimum, which the clamp itself guarantees. They also assume the halt and buffer inputs are clean synchronous levels.

The stimulus stays inside these assumptions. It drives every input half a cycle away from the sampling edge. It draws pulse and window values at random, including zero and other values below the minimum. It sends extra sync requests, `chip_rst_en` changes and configuration writes only while a sequence is running, which is where R7 and R8 say they must have no effect on that sequence.

// File: rtl/sync_shutter_pkg.sv
package sync_shutter_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PRE   = 2'd1,
    SQ_PULSE = 2'd2,
    SQ_POST  = 2'd3
  } sq_state_t;
endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs #(
  parameter int CW        = 16,
  parameter int MIN_PULSE = 1,
  parameter int MIN_WIN   = 65
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] pulse_len,
  output logic [CW-1:0] win_len
);
  localparam logic [CW-1:0] PMIN = CW'(MIN_PULSE);
  localparam logic [CW-1:0] WMIN = CW'(MIN_WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_len <= PMIN;
      win_len   <= WMIN;
    end else if (cfg_wr) begin
      if (!cfg_addr) pulse_len <= (cfg_wdata < PMIN) ? PMIN : cfg_wdata;
      else           win_len   <= (cfg_wdata < WMIN) ? WMIN : cfg_wdata;
    end
  end
endmodule

// File: rtl/sync_sequencer.sv
module sync_sequencer
  import sync_shutter_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_req,
  input  logic          chip_rst_en,
  input  logic [CW-1:0] pulse_len,
  input  logic [CW-1:0] win_len,
  output logic          active,
  output logic          t0_pulse,
  output logic          chip_rst,
  output logic          done
);
  localparam int NW = CW + 1;

  sq_state_t     state;
  logic [NW-1:0] cnt;
  logic [NW-1:0] lim_p;
  logic [NW-1:0] lim_last;
  logic          rst_en_q;
  logic [NW-1:0] p_ext;
  logic [NW-1:0] w_ext;
  logic [NW-1:0] span;

  always_comb begin
    p_ext = NW'(pulse_len);
    w_ext = NW'(win_len);
    span  = (w_ext > p_ext + NW'(2)) ? w_ext : p_ext + NW'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      lim_p    <= '0;
      lim_last <= '0;
      rst_en_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (sync_req) begin
          state    <= SQ_PRE;
          cnt      <= '0;
          lim_p    <= p_ext;
          lim_last <= span - NW'(1);
          rst_en_q <= chip_rst_en;
        end
        SQ_PRE: begin
          state <= SQ_PULSE;
          cnt   <= cnt + NW'(1);
        end
        SQ_PULSE: begin
          cnt <= cnt + NW'(1);
          if (cnt == lim_p) state <= SQ_POST;
        end
        SQ_POST: begin
          if (cnt == lim_last) begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + NW'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign active   = (state != SQ_IDLE);
  assign t0_pulse = (state == SQ_PULSE);
  assign chip_rst = (state == SQ_PULSE) && rst_en_q;
endmodule

// File: rtl/busy_merge.sv
module busy_merge #(
  parameter int NREMOTE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               buf_afull,
  input  logic               halt_set,
  input  logic               halt_clr,
  input  logic [NREMOTE-1:0] remote_busy,
  output logic               busy_local,
  output logic               busy_all
);
  logic halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        halt_q <= 1'b0;
    else if (halt_set) halt_q <= 1'b1;
    else if (halt_clr) halt_q <= 1'b0;
  end

  assign busy_local = buf_afull | halt_q;
  assign busy_all   = busy_local | (|remote_busy);
endmodule

// File: rtl/sync_shutter_ctrl.sv
module sync_shutter_ctrl #(
  parameter int CW        = 16,
  parameter int MIN_PULSE = 1,
  parameter int MIN_WIN   = 65,
  parameter int NREMOTE   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shutter_en,
  input  logic               sync_req,
  input  logic               chip_rst_en,
  input  logic               cfg_wr,
  input  logic               cfg_addr,
  input  logic [CW-1:0]      cfg_wdata,
  input  logic               buf_afull,
  input  logic               halt_set,
  input  logic               halt_clr,
  input  logic [NREMOTE-1:0] remote_busy,
  output logic               shutter_o,
  output logic               t0_sync_o,
  output logic               chip_rst_o,
  output logic               sync_done_o,
  output logic               busy_o,
  output logic               busy_all_o
);
  logic [CW-1:0] pulse_len;
  logic [CW-1:0] win_len;
  logic          seq_active;

  sync_cfg_regs #(.CW(CW), .MIN_PULSE(MIN_PULSE), .MIN_WIN(MIN_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pulse_len(pulse_len), .win_len(win_len)
  );

  sync_sequencer #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .chip_rst_en(chip_rst_en),
    .pulse_len(pulse_len), .win_len(win_len), .active(seq_active),
    .t0_pulse(t0_sync_o), .chip_rst(chip_rst_o), .done(sync_done_o)
  );

  busy_merge #(.NREMOTE(NREMOTE)) u_busy (
    .clk(clk), .rst_n(rst_n), .buf_afull(buf_afull), .halt_set(halt_set),
    .halt_clr(halt_clr), .remote_busy(remote_busy),
    .busy_local(busy_o), .busy_all(busy_all_o)
  );

  assign shutter_o = shutter_en && !seq_active;
endmodule

// File: rtl/sync_shutter_chk.sv
module sync_shutter_chk #(
  parameter int MIN_WIN = 65,
  parameter int NREMOTE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shutter_en,
  input logic               seq_active,
  input logic               shutter_o,
  input logic               t0_sync_o,
  input logic               chip_rst_o,
  input logic               sync_done_o,
  input logic               buf_afull,
  input logic               halt_set,
  input logic               busy_o,
  input logic               busy_all_o,
  input logic [NREMOTE-1:0] remote_busy
);
  logic [31:0] win_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          win_cnt <= '0;
    else if (seq_active) win_cnt <= win_cnt + 32'd1;
    else                 win_cnt <= '0;
  end

  assert_t0_shutter_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t0_sync_o |-> !shutter_o);
  assert_window_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done_o |-> (win_cnt >= 32'(MIN_WIN)));
  assert_rst_inside_t0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_o |-> t0_sync_o);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done_o |=> !sync_done_o);
  assert_done_reopen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done_o |-> (shutter_o == shutter_en) && !t0_sync_o);
  assert_afull_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_afull |-> busy_o);
  assert_halt_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set |=> busy_o);
  assert_combine_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || (|remote_busy)) |-> busy_all_o);
endmodule

bind sync_shutter_ctrl sync_shutter_chk #(.MIN_WIN(MIN_WIN), .NREMOTE(NREMOTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutter_en(shutter_en), .seq_active(seq_active),
  .shutter_o(shutter_o), .t0_sync_o(t0_sync_o), .chip_rst_o(chip_rst_o),
  .sync_done_o(sync_done_o), .buf_afull(buf_afull), .halt_set(halt_set),
  .busy_o(busy_o), .busy_all_o(busy_all_o), .remote_busy(remote_busy)
);

// File: tb/tb_sync_shutter_ctrl.sv
module tb_sync_shutter_ctrl;
  localparam int CW = 16;
  localparam int MINP = 1;
  localparam int MINW = 65;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutter_en = 1'b1, sync_req = 1'b0, chip_rst_en = 1'b0;
  logic cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic buf_afull = 1'b0, halt_set = 1'b0, halt_clr = 1'b0;
  logic [NR-1:0] remote_busy = '0;
  logic shutter_o, t0_sync_o, chip_rst_o, sync_done_o, busy_o, busy_all_o;

  int checks = 0;
  int errors = 0;
  int mp = MINP;
  int mw = MINW;
  bit mhalt = 1'b0;

  always #2.5 clk = ~clk;

  sync_shutter_ctrl #(.CW(CW), .MIN_PULSE(MINP), .MIN_WIN(MINW), .NREMOTE(NR)) dut (
    .clk(clk), .rst_n(rst_n), .shutter_en(shutter_en), .sync_req(sync_req),
    .chip_rst_en(chip_rst_en), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_afull(buf_afull), .halt_set(halt_set),
    .halt_clr(halt_clr), .remote_busy(remote_busy), .shutter_o(shutter_o),
    .t0_sync_o(t0_sync_o), .chip_rst_o(chip_rst_o), .sync_done_o(sync_done_o),
    .busy_o(busy_o), .busy_all_o(busy_all_o)
  );

  function automatic int clampv(int v, int m);
    return (v < m) ? m : v;
  endfunction

  function automatic int span(int p, int w);
    return (w > p + 2) ? w : p + 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cfg_write(bit a, int v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = CW'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a) mw = clampv(v, MINW); else mp = clampv(v, MINP);
  endtask

  // One full sequence, checked cycle by cycle.
  // poke: extra sync_req, chip_rst_en toggle and config write while running.
  task automatic run_seq(bit en, bit poke);
    int L, p, nv;
    bit na;
    p = mp;
    L = span(mp, mw);
    na = 1'b0; nv = 0;
    @(negedge clk);
    sync_req = 1'b1; chip_rst_en = en;
    @(negedge clk);
    sync_req = 1'b0;
    for (int j = 0; j <= L; j++) begin
      chk("R4", "shutter", int'(shutter_o), (j < L) ? 0 : 1);
      chk("R3", "t0", int'(t0_sync_o), (j >= 1 && j <= p) ? 1 : 0);
      chk("R5", "chip_rst", int'(chip_rst_o), (en && j >= 1 && j <= p) ? 1 : 0);
      chk("R6", "done", int'(sync_done_o), (j == L) ? 1 : 0);
      if (j == 0) chk("R2", "closed after req", int'(shutter_o), 0);
      if (j == 1) chk("R2", "t0 one after close", int'(t0_sync_o), 1);
      sync_req = 1'b0; cfg_wr = 1'b0;
      if (poke && j == 2) begin
        sync_req = 1'b1;
        chip_rst_en = ~en;
      end
      if (poke && j == 3) begin
        na = 1'(($urandom % 2));
        nv = int'($urandom % 130);
        cfg_wr = 1'b1; cfg_addr = na; cfg_wdata = CW'(nv);
      end
      @(negedge clk);
    end
    sync_req = 1'b0; cfg_wr = 1'b0;
    if (poke) begin
      if (na) mw = clampv(nv, MINW); else mp = clampv(nv, MINP);
      chk("R7", "no restart shutter", int'(shutter_o), 1);
      chk("R7", "no restart t0", int'(t0_sync_o), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "t0 in reset", int'(t0_sync_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "shutter open", int'(shutter_o), 1);
    chk("R1", "t0 low", int'(t0_sync_o), 0);
    chk("R1", "rst low", int'(chip_rst_o), 0);
    chk("R1", "done low", int'(sync_done_o), 0);
    chk("R1", "busy low", int'(busy_o), 0);
    shutter_en = 1'b0;
    @(negedge clk);
    chk("R1", "shutter follows enable", int'(shutter_o), 0);
    shutter_en = 1'b1;

    // Default sequence: P=1, W=65
    run_seq(1'b0, 1'b0);
    run_seq(1'b1, 1'b0);
    // R8 clamp: zero values go to minimum
    cfg_write(1'b0, 0);
    cfg_write(1'b1, 3);
    run_seq(1'b1, 1'b0);
    // Long pulse beyond window: P+2 dominates
    cfg_write(1'b0, 70);
    cfg_write(1'b1, 66);
    run_seq(1'b1, 1'b0);
    // R7/R8 during run
    cfg_write(1'b0, 4);
    cfg_write(1'b1, 80);
    run_seq(1'b0, 1'b1);
    // Random configurations
    for (int k = 0; k < 12; k++) begin
      cfg_write(1'b0, int'($urandom % 12));
      cfg_write(1'b1, int'($urandom % 120));
      run_seq(1'($urandom % 2), 1'($urandom % 2));
    end

    // R9/R10 busy: random stimulus plus directed set/clear collision
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      buf_afull = 1'(($urandom % 4) == 0);
      remote_busy = NR'(($urandom % 3 == 0) ? $urandom : 0);
      halt_set = 1'(($urandom % 8) == 0);
      halt_clr = 1'(($urandom % 6) == 0);
      if (k == 10) begin halt_set = 1'b1; halt_clr = 1'b1; end
      @(posedge clk);
      if (halt_set) mhalt = 1'b1; else if (halt_clr) mhalt = 1'b0;
      @(negedge clk);
      chk("R9", "busy_o", int'(busy_o), int'(buf_afull | mhalt));
      chk("R10", "busy_all_o", int'(busy_all_o), int'(buf_afull | mhalt | (|remote_busy)));
      halt_set = 1'b0; halt_clr = 1'b0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule